// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This block takes a DDR SDRAM from power-up to a usable state. Once reset is released it drives the memory command bus through a fixed start-up program. The program begins with a long idle stretch of NOP commands. It then issues precharge-all, an extended register load, precharge-all again, two auto-refreshes and a base register load. After that comes a counted quiet period, and only when it ends does the block allow user traffic. Each command is held on the bus for exactly one cycle. Every wait between commands is counted by one shared down-counter, which is reloaded by each command.

The sequencer is a single state machine. Its states, in order, are:

- `S_POWER_WAIT` → `S_PRE_A` → `S_TRP_A` → `S_LOAD_EXT` → `S_TMRD` → `S_PRE_B` → `S_TRP_B` → `S_REF_A` → `S_TRFC_A` → `S_REF_B` → `S_TRFC_B` → `S_LOAD_BASE` → `S_HOLDOFF` → `S_READY`.

The transitions work as follows:

- Each command state (`S_PRE_*`, `S_LOAD_*`, `S_REF_*`) moves to the state after it unconditionally and loads the timer.
- Each wait state (`S_POWER_WAIT`, `S_TRP_*`, `S_TMRD`, `S_TRFC_*`, `S_HOLDOFF`) moves on when the timer reaches zero.
- `S_READY` holds until reset.
- An asynchronous active-low reset returns the machine to `S_POWER_WAIT` from any state.

All wait counts (`IDLE_CYC`, `T_RP`, `T_MRD`, `T_RFC`, `HOLD_CYC`) are given in clock cycles and must be at least 1. The default `IDLE_CYC` equals 200 µs at 250 MHz.

Top module: `ddr_powerup_seq`

## Requirements
- R1: After reset is released, the command bus carries only NOP for exactly `IDLE_CYC` cycles (cycles 0 to `IDLE_CYC`-1). The first command appears in cycle `IDLE_CYC`.
- R2: Commands are encoded as {cs_n, ras_n, cas_n, we_n}: NOP = 0111, precharge-all = 0010, auto-refresh = 0001, register load = 0000. While reset is held the bus shows NOP.
- R3: The sequence contains exactly six commands, in this order: precharge-all, extended register load, precharge-all, auto-refresh, auto-refresh, base register load. No command follows them.
- R4: A precharge-all drives `addr[PRE_BIT]` high, every other address bit low, and the bank to 0.
- R5: The first register load drives bank 1, `addr = EXT_VAL` and `ext_sel = 1`. The second register load drives bank 0, `addr = BASE_VAL` and `ext_sel = 0`.
- R6: The bus carries exactly `T_RP` NOP cycles after each precharge-all, `T_MRD` after the extended load, and `T_RFC` after each auto-refresh.
- R7: `req_gate` stays low during the `HOLD_CYC` NOP cycles that follow the base register load and rises in the cycle after them. While `req_gate` is high the bus carries only NOP.
- R8: `init_done` is low during reset and during the sequence. It rises in the same cycle as `req_gate` and stays high until the next reset.
- R9: A reset asserted at any point, including a cycle in which a command is on the bus, aborts the sequence. After release the full program restarts from the idle stretch.
- R10: During NOP cycles, `addr`, `ba` and `ext_sel` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address; register select during loads |
| addr | output | ADDR_W | Address bus; register value during loads, precharge-all bit during precharge |
| ext_sel | output | 1 | High while the extended register value is being loaded |
| init_done | output | 1 | Initialization complete |
| req_gate | output | 1 | High when user read/write requests may be accepted |

## Verification
Two events can meet in a single cycle: a reset and a command being driven on the bus. The bench provokes this by asserting reset just after the clock edge that enters the first auto-refresh state. The refresh must never be observed, the three outstanding commands must stay unconsumed, and the replayed program must match the full schedule from cycle zero. A second coincidence is the end of the holdoff and the rise of both completion flags. It is judged by requiring `req_gate` and `init_done` to flip in the one computed cycle and never before.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_LMR
    } init_cmd_e;

    typedef enum logic [3:0] {
        S_POWER_WAIT,
        S_PRE_A,
        S_TRP_A,
        S_LOAD_EXT,
        S_TMRD,
        S_PRE_B,
        S_TRP_B,
        S_REF_A,
        S_TRFC_A,
        S_REF_B,
        S_TRFC_B,
        S_LOAD_BASE,
        S_HOLDOFF,
        S_READY
    } init_state_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned min2(int unsigned a, int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/init_cmd_enc.sv
module init_cmd_enc
    import ddr_init_pkg::*;
(
    input  init_cmd_e cmd,
    output logic      cs_n,
    output logic      ras_n,
    output logic      cas_n,
    output logic      we_n
);
    always_comb begin
        unique case (cmd)
            CMD_NOP: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            CMD_PRE: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            CMD_REF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            CMD_LMR: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        endcase
    end
endmodule

// File: rtl/ddr_powerup_seq.sv
module ddr_powerup_seq
    import ddr_init_pkg::*;
#(
    parameter int unsigned IDLE_CYC = 50000,
    parameter int unsigned T_RP     = 4,
    parameter int unsigned T_MRD    = 2,
    parameter int unsigned T_RFC    = 18,
    parameter int unsigned HOLD_CYC = 200,
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned BA_W     = 2,
    parameter int unsigned PRE_BIT  = 10,
    parameter int unsigned EXT_VAL  = 'h000,
    parameter int unsigned BASE_VAL = 'h032
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ext_sel,
    output logic              init_done,
    output logic              req_gate
);
    localparam int unsigned MAX_WAIT =
        max2(max2(IDLE_CYC, HOLD_CYC), max2(T_RP, max2(T_MRD, T_RFC)));
    localparam int unsigned CNT_W = $clog2(MAX_WAIT + 1);

    init_state_e      st, nxt;
    init_cmd_e        cmd;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             expired;

    // Shared down-counter; reset value covers the power-up idle stretch.
    init_wait_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (IDLE_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    init_cmd_enc u_enc (
        .cmd   (cmd),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_POWER_WAIT;
        end else begin
            st <= nxt;
        end
    end

    // Transitions and timer loads: each command state arms the wait that follows it.
    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            S_POWER_WAIT: if (expired) nxt = S_PRE_A;
            S_PRE_A: begin
                nxt      = S_TRP_A;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_RP - 1);
            end
            S_TRP_A:      if (expired) nxt = S_LOAD_EXT;
            S_LOAD_EXT: begin
                nxt      = S_TMRD;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_MRD - 1);
            end
            S_TMRD:       if (expired) nxt = S_PRE_B;
            S_PRE_B: begin
                nxt      = S_TRP_B;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_RP - 1);
            end
            S_TRP_B:      if (expired) nxt = S_REF_A;
            S_REF_A: begin
                nxt      = S_TRFC_A;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_RFC - 1);
            end
            S_TRFC_A:     if (expired) nxt = S_REF_B;
            S_REF_B: begin
                nxt      = S_TRFC_B;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_RFC - 1);
            end
            S_TRFC_B:     if (expired) nxt = S_LOAD_BASE;
            S_LOAD_BASE: begin
                nxt      = S_HOLDOFF;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(HOLD_CYC - 1);
            end
            S_HOLDOFF:    if (expired) nxt = S_READY;
            S_READY:      nxt = S_READY;
            default:      nxt = S_POWER_WAIT;
        endcase
    end

    // Outputs decoded from the current state only.
    always_comb begin
        cmd       = CMD_NOP;
        ba        = '0;
        addr      = '0;
        ext_sel   = 1'b0;
        init_done = 1'b0;
        req_gate  = 1'b0;
        unique case (st)
            S_PRE_A, S_PRE_B: begin
                cmd           = CMD_PRE;
                addr[PRE_BIT] = 1'b1;
            end
            S_LOAD_EXT: begin
                cmd     = CMD_LMR;
                ba      = BA_W'(1);
                addr    = ADDR_W'(EXT_VAL);
                ext_sel = 1'b1;
            end
            S_REF_A, S_REF_B: cmd = CMD_REF;
            S_LOAD_BASE: begin
                cmd  = CMD_LMR;
                addr = ADDR_W'(BASE_VAL);
            end
            S_READY: begin
                init_done = 1'b1;
                req_gate  = 1'b1;
            end
            default: cmd = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/init_seq_chk.sv
module init_seq_chk
    import ddr_init_pkg::*;
#(
    parameter int unsigned IDLE_CYC = 50000,
    parameter int unsigned T_RP     = 4,
    parameter int unsigned T_MRD    = 2,
    parameter int unsigned T_RFC    = 18,
    parameter int unsigned HOLD_CYC = 200,
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned PRE_BIT  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done,
    input logic              req_gate
);
    localparam int unsigned MIN_GAP = min2(T_RP, min2(T_MRD, T_RFC));
    localparam int unsigned SAT     = max2(IDLE_CYC, max2(HOLD_CYC, MIN_GAP));
    localparam int unsigned CW      = $clog2(SAT + 1);

    logic [3:0]    pins;
    logic          is_nop, is_pre, is_ref;
    logic [CW-1:0] since_rst, nop_run;
    logic          seen_cmd;
    logic [1:0]    ref_cnt;

    assign pins   = {cs_n, ras_n, cas_n, we_n};
    assign is_nop = (pins == 4'b0111);
    assign is_pre = (pins == 4'b0010);
    assign is_ref = (pins == 4'b0001);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            nop_run   <= '0;
            seen_cmd  <= 1'b0;
            ref_cnt   <= '0;
        end else begin
            if (since_rst != CW'(SAT)) since_rst <= since_rst + 1'b1;
            if (!is_nop) begin
                nop_run  <= '0;
                seen_cmd <= 1'b1;
            end else if (nop_run != CW'(SAT)) begin
                nop_run <= nop_run + 1'b1;
            end
            if (is_ref && ref_cnt != 2'd3) ref_cnt <= ref_cnt + 1'b1;
        end
    end

    p_idle_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < CW'(IDLE_CYC)) |-> is_nop);

    p_pre_a10_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> addr[PRE_BIT]);

    p_gap_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_nop && seen_cmd) |-> (nop_run >= CW'(MIN_GAP)));

    p_ref_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cnt <= 2'd2);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_gate) |-> (nop_run >= CW'(HOLD_CYC)));

    p_gate_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_gate |-> is_nop);

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
endmodule

bind ddr_powerup_seq init_seq_chk #(
    .IDLE_CYC (IDLE_CYC),
    .T_RP     (T_RP),
    .T_MRD    (T_MRD),
    .T_RFC    (T_RFC),
    .HOLD_CYC (HOLD_CYC),
    .ADDR_W   (ADDR_W),
    .PRE_BIT  (PRE_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .init_done (init_done),
    .req_gate  (req_gate)
);

// File: tb/ddr_powerup_seq_tb_top.sv
module ddr_powerup_seq_tb_top;
    localparam int TB_IDLE = 40;
    localparam int TB_RP   = 3;
    localparam int TB_MRD  = 2;
    localparam int TB_RFC  = 7;
    localparam int TB_HOLD = 200;
    localparam int TB_AW   = 13;
    localparam int TB_BW   = 2;
    localparam int TB_PBIT = 10;
    localparam int TB_EXT  = 'h0A5;
    localparam int TB_BASE = 'h132;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n, ras_n, cas_n, we_n;
    logic [TB_BW-1:0]  ba;
    logic [TB_AW-1:0]  addr;
    logic              ext_sel, init_done, req_gate;

    always #2 clk = ~clk;

    ddr_powerup_seq #(
        .IDLE_CYC (TB_IDLE),
        .T_RP     (TB_RP),
        .T_MRD    (TB_MRD),
        .T_RFC    (TB_RFC),
        .HOLD_CYC (TB_HOLD),
        .ADDR_W   (TB_AW),
        .BA_W     (TB_BW),
        .PRE_BIT  (TB_PBIT),
        .EXT_VAL  (TB_EXT),
        .BASE_VAL (TB_BASE)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr),
        .ext_sel   (ext_sel),
        .init_done (init_done),
        .req_gate  (req_gate)
    );

    typedef struct {
        int        cyc;
        logic [3:0] pins;
        int        ba;
        int        addr;
        int        sel;
        string     name;
        string     req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   ready_cyc = 0;
    int   ref1_cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   reported = 0;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic push(int c, logic [3:0] p, int b, int a, int s, string n, string r);
        exp_t e;
        e.cyc = c; e.pins = p; e.ba = b; e.addr = a; e.sel = s; e.name = n; e.req = r;
        exp_q.push_back(e);
    endtask

    // Driver: builds the expected schedule from the requirements (R1, R3-R7).
    task automatic plan_run();
        int t;
        exp_q.delete();
        t = TB_IDLE;
        push(t, 4'b0010, 0, 1 << TB_PBIT, 0, "precharge A", "R4");
        t += 1 + TB_RP;
        push(t, 4'b0000, 1, TB_EXT, 1, "extended load", "R5");
        t += 1 + TB_MRD;
        push(t, 4'b0010, 0, 1 << TB_PBIT, 0, "precharge B", "R4");
        t += 1 + TB_RP;
        ref1_cyc = t;
        push(t, 4'b0001, 0, 0, 0, "refresh A", "R3");
        t += 1 + TB_RFC;
        push(t, 4'b0001, 0, 0, 0, "refresh B", "R3");
        t += 1 + TB_RFC;
        push(t, 4'b0000, 0, TB_BASE, 0, "base load", "R5");
        ready_cyc = t + 1 + TB_HOLD;
    endtask

    // Monitor: samples at the falling edge, pops and compares expected commands.
    always @(negedge clk) begin
        logic [3:0] pins;
        bit         exp_gate;
        pins = {cs_n, ras_n, cas_n, we_n};
        if (!rst_n) begin
            chk(pins == 4'b0111, "R2", "bus during reset", int'(pins), 7);
            chk(!req_gate && !init_done, "R8", "flags during reset",
                int'({req_gate, init_done}), 0);
            cyc = 0;
        end else begin
            if (cyc < TB_IDLE) chk(pins == 4'b0111, "R1", "idle stretch NOP", int'(pins), 7);
            if (pins != 4'b0111) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "command after sequence end", int'(pins), 7);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(cyc == e.cyc, "R6", {e.name, " issue cycle"}, cyc, e.cyc);
                    chk(pins == e.pins, "R3", {e.name, " encoding"}, int'(pins), int'(e.pins));
                    chk(int'(ba) == e.ba, e.req, {e.name, " bank"}, int'(ba), e.ba);
                    chk(int'(addr) == e.addr, e.req, {e.name, " address"}, int'(addr), e.addr);
                    chk(int'(ext_sel) == e.sel, e.req, {e.name, " ext_sel"}, int'(ext_sel), e.sel);
                end
            end else begin
                chk(addr == '0 && ba == '0 && !ext_sel, "R10", "NOP side fields",
                    int'(addr), 0);
            end
            exp_gate = (cyc >= ready_cyc);
            chk(req_gate == exp_gate, "R7", "request gate", int'(req_gate), int'(exp_gate));
            chk(init_done == exp_gate, "R8", "init_done", int'(init_done), int'(exp_gate));
            cyc++;
        end
    end

    initial begin
        // Run 1: full sequence from reset
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        plan_run();
        @(posedge clk); #1 rst_n = 1'b1;
        wait (cyc == ready_cyc + 30);
        chk(exp_q.size() == 0, "R3", "commands left after run 1", exp_q.size(), 0);

        // Run 2: reset lands while the first refresh is on the bus (R9)
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        plan_run();
        @(posedge clk); #1 rst_n = 1'b1;
        wait (cyc == ref1_cyc);
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        chk(exp_q.size() == 3, "R9", "commands pending after aborted run",
            exp_q.size(), 3);

        // Run 3: full restart after the abort (R9)
        plan_run();
        @(posedge clk); #1 rst_n = 1'b1;
        wait (cyc == ready_cyc + 30);
        chk(exp_q.size() == 0, "R9", "commands left after restarted run", exp_q.size(), 0);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        report();
    end
endmodule